// File: doc/BRIEF.md
# Comparator Event Interrupt Controller

The block watches a single comparator output that is not related to the local clock. It brings that signal into the clock domain through a synchronizer chain and detects transitions on the synchronized level. A two-bit mode field selects the transitions that count as events: any change, falling edges only or rising edges only. One encoding is reserved and never produces an event. A detected event sets a sticky flag. The block asserts an interrupt request while the flag, a local enable bit and a chip-wide interrupt enable are all high.

Software controls the block through one byte-wide control/status register, with a write strobe and a read strobe. The flag can be cleared in two ways: software writes a one to the flag bit, or the interrupt controller sends an acknowledge pulse when it takes the vector. If an event and a clear fall in the same cycle, the event wins. A capture-enable bit routes the synchronized comparator level to a trigger output for a capture timer. While that bit is low the trigger output is held at zero.

Mode changes are not filtered. Software is expected to drop the local enable before it changes the mode.

Top module: `cmp_evt_irq`

## Requirements
- R1: After reset, every register bit reads 0, irqReq is 0 and capTrig is 0.
- R2: A write with wrEn loads bit 3 (interrupt enable), bit 2 (capture enable) and bits 1:0 (mode). With rdEn high, rdData returns {2'b00, level, flag, irqEn, capEn, mode[1:0]}, with bit 5 the synchronized level and bit 4 the flag. With rdEn low, rdData is 0.
- R3: A change on cmpIn shows in rdData bit 5, and in capTrig when capture is enabled, exactly SYNC_STAGES rising clock edges later.
- R4: In mode 2'b00, every change of the synchronized level sets the flag one clock edge after the level changes.
- R5: In mode 2'b10, only a 1-to-0 change sets the flag. In mode 2'b11, only a 0-to-1 change sets the flag.
- R6: In mode 2'b01, the flag is never set.
- R7: irqReq is high exactly when the flag, the interrupt enable and globalIe are all 1.
- R8: A one-cycle intAck pulse clears the flag on the next edge.
- R9: A write with bit 4 set clears the flag. A write with bit 4 clear leaves the flag unchanged.
- R10: When an event coincides with intAck or with a write-one clear, the flag stays set.
- R11: capTrig follows the synchronized level while the capture enable is 1, and is held at 0 while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmpIn | input | 1 | Asynchronous comparator output |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdEn | input | 1 | Register read strobe |
| rdData | output | 8 | Register read data |
| globalIe | input | 1 | Chip-wide interrupt enable |
| intAck | input | 1 | Vector acknowledge pulse for this source |
| irqReq | output | 1 | Interrupt request |
| capTrig | output | 1 | Trigger to the capture timer |

## Verification
The bench builds the block with SYNC_STAGES = 3 instead of the default 2. The extra stage makes the latency check in R3 depend on the parameter rather than on a fixed constant. The reference model takes its delay from the same parameter value, and holds the comparator history in a queue of that length. Holding the acknowledge high across a whole synchronizer window makes it fall in the same cycle as an event, which tests the set-wins rule.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;

  localparam int REG_W     = 8;
  localparam int BIT_LEVEL = 5;
  localparam int BIT_FLAG  = 4;
  localparam int BIT_IEN   = 3;
  localparam int BIT_CAP   = 2;

  typedef enum logic [1:0] {
    MODE_ANY  = 2'b00,
    MODE_RSVD = 2'b01,
    MODE_FALL = 2'b10,
    MODE_RISE = 2'b11
  } evtMode_t;

  // control -> datapath
  typedef struct packed {
    logic     capEn;
    evtMode_t mode;
  } dpCtrl_t;

  // datapath -> control
  typedef struct packed {
    logic evt;
    logic level;
  } dpStat_t;

endpackage

// File: rtl/cmp_evt_datapath.sv
module cmp_evt_datapath
  import cmp_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmpIn,
  input  dpCtrl_t ctrl,
  output dpStat_t stat,
  output logic    capTrig
);

  logic [SYNC_STAGES-1:0] syncPipe;
  logic                   levelDly;
  logic                   level;
  logic                   rose;
  logic                   fell;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncPipe[0] <= 1'b0;
          else       syncPipe[0] <= cmpIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncPipe[s] <= 1'b0;
          else       syncPipe[s] <= syncPipe[s-1];
        end
      end
    end
  endgenerate

  assign level = syncPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) levelDly <= 1'b0;
    else       levelDly <= level;
  end

  assign rose = level & ~levelDly;
  assign fell = ~level & levelDly;

  always_comb begin
    unique case (ctrl.mode)
      MODE_ANY:  stat.evt = rose | fell;
      MODE_FALL: stat.evt = fell;
      MODE_RISE: stat.evt = rose;
      default:   stat.evt = 1'b0;
    endcase
  end

  assign stat.level = level;
  assign capTrig    = ctrl.capEn & level;

  AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.mode == MODE_RSVD) |-> !stat.evt); // R6

  AST_LEVEL_LAG: assert property (@(posedge clk) disable iff (!rstN)
    (levelDly != level) |=> (levelDly == $past(level))); // R3

endmodule

// File: rtl/cmp_evt_ctrl.sv
module cmp_evt_ctrl
  import cmp_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdEn,
  output logic [REG_W-1:0] rdData,
  input  logic             globalIe,
  input  logic             intAck,
  input  dpStat_t          stat,
  output dpCtrl_t          ctrl,
  output logic             irqReq
);

  logic     flag;
  logic     irqEn;
  logic     capEn;
  evtMode_t mode;
  logic     swClear;
  logic     anyClear;

  assign swClear  = wrEn & wrData[BIT_FLAG];
  assign anyClear = swClear | intAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn <= 1'b0;
      capEn <= 1'b0;
      mode  <= MODE_ANY;
    end else if (wrEn) begin
      irqEn <= wrData[BIT_IEN];
      capEn <= wrData[BIT_CAP];
      mode  <= evtMode_t'(wrData[1:0]);
    end
  end

  // event has priority over either clear path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         flag <= 1'b0;
    else if (stat.evt) flag <= 1'b1;
    else if (anyClear) flag <= 1'b0;
  end

  assign ctrl.capEn = capEn;
  assign ctrl.mode  = mode;
  assign irqReq     = flag & irqEn & globalIe;

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      rdData[BIT_LEVEL] = stat.level;
      rdData[BIT_FLAG]  = flag;
      rdData[BIT_IEN]   = irqEn;
      rdData[BIT_CAP]   = capEn;
      rdData[1:0]       = mode;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    stat.evt |=> flag); // R10

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !stat.evt) |=> !flag); // R8

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[BIT_FLAG] && !stat.evt) |=> !flag); // R9

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stat.evt && !intAck && !(wrEn && wrData[BIT_FLAG])) |=> $stable(flag)); // R9

endmodule

// File: rtl/cmp_evt_irq.sv
module cmp_evt_irq
  import cmp_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmpIn,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       rdEn,
  output logic [7:0] rdData,
  input  logic       globalIe,
  input  logic       intAck,
  output logic       irqReq,
  output logic       capTrig
);

  dpCtrl_t dpCtrl;
  dpStat_t dpStat;

  cmp_evt_datapath #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .cmpIn   (cmpIn),
    .ctrl    (dpCtrl),
    .stat    (dpStat),
    .capTrig (capTrig)
  );

  cmp_evt_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .rdEn     (rdEn),
    .rdData   (rdData),
    .globalIe (globalIe),
    .intAck   (intAck),
    .stat     (dpStat),
    .ctrl     (dpCtrl),
    .irqReq   (irqReq)
  );

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> globalIe); // R7

  AST_CAP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    capTrig |-> dpCtrl.capEn); // R11

endmodule

// File: tb/sim_cmp_evt_irq.sv
module sim_cmp_evt_irq;

  localparam int NSYNC = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmpIn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rdEn = 1'b1;
  logic       globalIe = 1'b0;
  logic       intAck = 1'b0;
  logic [7:0] rdData;
  logic       irqReq;
  logic       capTrig;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string curReq = "R1";

  always #5 clk = ~clk;

  cmp_evt_irq #(.SYNC_STAGES(NSYNC)) u0 (
    .clk(clk), .rstN(rstN), .cmpIn(cmpIn), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .globalIe(globalIe), .intAck(intAck),
    .irqReq(irqReq), .capTrig(capTrig)
  );

  // behavioural reference model
  bit   hist[$];
  bit   mDly, mFlag, mIen, mCap;
  bit [1:0] mMode;

  function automatic void modelReset();
    hist.delete();
    for (int i = 0; i < NSYNC; i++) hist.push_back(1'b0);
    mDly = 0; mFlag = 0; mIen = 0; mCap = 0; mMode = 2'b00;
  endfunction

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      bit lvl, ev, clr;
      lvl = hist[0];
      case (mMode)
        2'b00:   ev = (lvl != mDly);
        2'b10:   ev = (mDly && !lvl);
        2'b11:   ev = (!mDly && lvl);
        default: ev = 1'b0;
      endcase
      clr = intAck || (wrEn && wrData[4]);
      if (ev) mFlag = 1;
      else if (clr) mFlag = 0;
      if (wrEn) begin
        mIen = wrData[3]; mCap = wrData[2]; mMode = wrData[1:0];
      end
      mDly = lvl;
      void'(hist.pop_front());
      hist.push_back(cmpIn);
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      bit [7:0] expRd;
      expRd = rdEn ? {2'b00, hist[0], mFlag, mIen, mCap, mMode} : 8'h00;
      check("rdData", rdData, expRd);
      check("irqReq", irqReq, mFlag && mIen && globalIe);
      check("capTrig", capTrig, mCap && hist[0]);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wrReg(bit [7:0] v);
    wrEn = 1; wrData = v;
    cyc(1);
    wrEn = 0; wrData = 8'h00;
  endtask

  task automatic flip(int gap);
    cmpIn = ~cmpIn;
    cyc(gap);
  endtask

  initial begin
    cyc(3);
    // R1: outputs in reset
    checks++;
    if (rdData !== 8'h00 || irqReq !== 1'b0 || capTrig !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual %0h/%0b/%0b expected 0/0/0", rdData, irqReq, capTrig);
    end
    rstN = 1;
    cyc(3);

    curReq = "R2";
    wrReg(8'hCE);
    cyc(2);
    rdEn = 0; cyc(2); rdEn = 1;
    wrReg(8'h01);
    cyc(1);

    curReq = "R3";
    wrReg(8'h00);
    flip(1); flip(5); flip(2); cyc(6);

    curReq = "R4";
    globalIe = 1;
    wrReg(8'h08);
    flip(8);
    wrReg(8'h18);
    flip(8);
    wrReg(8'h18);
    cyc(2);

    curReq = "R5";
    wrReg(8'h0A);
    flip(8); wrReg(8'h1A); flip(8); wrReg(8'h1A);
    wrReg(8'h0B);
    flip(8); wrReg(8'h1B); flip(8); wrReg(8'h1B);

    curReq = "R6";
    wrReg(8'h09);
    flip(6); flip(6); flip(1); flip(6);

    curReq = "R7";
    wrReg(8'h08);
    flip(8);
    globalIe = 0; cyc(3); globalIe = 1; cyc(2);
    wrReg(8'h00); cyc(2); wrReg(8'h08); cyc(2);

    curReq = "R8";
    intAck = 1; cyc(1); intAck = 0; cyc(3);

    curReq = "R9";
    flip(8);
    wrReg(8'h08); cyc(2);
    wrReg(8'h18); cyc(2);

    curReq = "R10";
    cmpIn = ~cmpIn;
    intAck = 1; cyc(NSYNC + 4); intAck = 0; cyc(2);
    cmpIn = ~cmpIn;
    for (int i = 0; i < NSYNC + 3; i++) wrReg(8'h18);
    cyc(2);

    curReq = "R11";
    wrReg(8'h04);
    flip(6); flip(6);
    wrReg(8'h00);
    flip(6); flip(6);
    wrReg(8'h04); cyc(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule